// File: doc/BRIEF.md
# Left-Justified Stereo Audio Receiver

This block takes a two-channel PCM stream on a three-wire serial audio link (bit clock, word select, serial data) and turns it into one 16-bit two's-complement sample per channel. The three link wires are brought into the system clock domain through synchronizers. The bit clock is oversampled, and data and word select are taken on each rising bit-clock edge. Each word-select transition closes the word in progress and starts the word for the other channel. The closed word is then written to that channel's output register, and the channel's valid strobe is pulsed for one system clock cycle.

Two control inputs adapt the receiver to the transmitter. `cfg_ws_invert` swaps which word-select level means left. `cfg_msb_aligned` selects whether the MSB arrives on the bit-clock edge where word select changes, or one bit clock later. Words longer than 16 bits lose their extra low-order bits. Words shorter than 16 bits are padded with zeros at the bottom of the sample.

Top module: `lj_stereo_rx`

## Requirements
- R1: While `rst` is high, both samples are held at zero and both valid strobes are low.
- R2: With `cfg_ws_invert`=0, a word sent while word select is 0 is delivered on the left outputs and a word sent while it is 1 on the right outputs; with `cfg_ws_invert`=1 the mapping is swapped.
- R3: Serial bits are taken MSB first: the first data bit of a word lands in sample bit 15, and each later bit lands in the next lower position, so a two's-complement word is reproduced unchanged.
- R4: When a word carries more than 16 data bits, only the first 16 are kept; the rest have no effect on the sample.
- R5: When a word carries fewer than 16 data bits, the sample bits below the last received bit are zero.
- R6: With `cfg_msb_aligned`=0, the MSB of a word is the bit taken one bit clock after word select changes. The bit taken on the edge where the change is first seen is the final bit of the word just ending, stored only if that word has fewer than 16 bits.
- R7: With `cfg_msb_aligned`=1, the bit taken on the bit-clock edge where the word-select change is first seen is the MSB of the new word.
- R8: Each word-select transition after the first commits the finished word to exactly one channel and pulses that channel's valid for exactly one system clock cycle; the two valids are never high together.
- R9: Each sample output keeps its value in every cycle in which its valid is low.
- R10: Bits received before the first word-select transition after reset never reach an output; the first strobe follows the second transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial bit clock (asynchronous to clk) |
| ws_i | input | 1 | Word select |
| sd_i | input | 1 | Serial data |
| cfg_ws_invert | input | 1 | 0: word select low is left; 1: word select high is left |
| cfg_msb_aligned | input | 1 | 0: MSB one bit clock after the word-select change; 1: MSB on the change |
| left_sample | output | 16 | Last committed left sample |
| left_valid | output | 1 | One-cycle strobe when left_sample is updated |
| right_sample | output | 16 | Last committed right sample |
| right_valid | output | 1 | One-cycle strobe when right_sample is updated |

## Verification
The hardest case to reach is the boundary bit in the delayed-MSB mode. On the edge where the word-select change is first seen, that bit belongs to the word that is ending, and it matters only when that word is short. It is reached by sending frames of 11 slots with the MSB delayed, so that ten data bits precede the change and the boundary bit becomes bit 5 of the committed sample. Frames of 24 and 20 slots cover truncation in both alignments. A leading partial frame before the first transition checks that stale bits are dropped. The bench model replays each driven slot and predicts every strobe and its value.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int NUM_CHANNELS = 2;

  function automatic chan_e chan_of(input logic ws, input logic invert);
    return (ws ^ invert) ? CH_RIGHT : CH_LEFT;
  endfunction
endpackage

// File: rtl/lj_sync.sv
module lj_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/lj_frame_ctl.sv
module lj_frame_ctl
  import lj_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sck_s,
  input  logic  ws_s,
  input  logic  invert_i,
  output logic  tick_o,
  output logic  edge_o,
  output logic  active_o,
  output logic  commit_o,
  output chan_e commit_ch_o
);
  logic  sck_d;
  logic  seen;
  logic  ws_prev;
  logic  active;
  chan_e cur_ch;

  assign tick_o      = sck_s & ~sck_d;
  assign edge_o      = tick_o & seen & (ws_s != ws_prev);
  assign active_o    = active;
  assign commit_o    = edge_o & active;
  assign commit_ch_o = cur_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      seen    <= 1'b0;
      ws_prev <= 1'b0;
      active  <= 1'b0;
      cur_ch  <= CH_LEFT;
    end else begin
      sck_d <= sck_s;
      if (tick_o) begin
        seen    <= 1'b1;
        ws_prev <= ws_s;
      end
      if (edge_o) begin
        active <= 1'b1;
        cur_ch <= chan_of(ws_s, invert_i);
      end
    end
  end
endmodule

// File: rtl/lj_word_asm.sv
module lj_word_asm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         edge_i,
  input  logic         active_i,
  input  logic         aligned_i,
  input  logic         sd_i,
  output logic [W-1:0] word_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  acc_app;
  logic [CW-1:0] cnt;
  logic          room;

  assign room = (cnt < CW'(W));

  always_comb begin
    acc_app = acc;
    if (room) acc_app[W - 1 - int'(cnt)] = sd_i;
  end

  // Delayed-MSB mode: the bit on the boundary edge closes the old word.
  assign word_o = aligned_i ? acc : acc_app;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else if (tick_i) begin
      if (edge_i) begin
        acc <= '0;
        cnt <= '0;
        if (aligned_i) begin
          acc[W-1] <= sd_i;
          cnt      <= CW'(1);
        end
      end else if (active_i && room) begin
        acc <= acc_app;
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lj_out_stage.sv
module lj_out_stage
  import lj_rx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit_i,
  input  chan_e        ch_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sample_o [NUM_CHANNELS],
  output logic         valid_o  [NUM_CHANNELS]
);
  for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        sample_o[c] <= '0;
        valid_o[c]  <= 1'b0;
      end else begin
        valid_o[c] <= 1'b0;
        if (commit_i && (int'(ch_i) == c)) begin
          sample_o[c] <= word_i;
          valid_o[c]  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lj_stereo_rx.sv
module lj_stereo_rx
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                cfg_ws_invert,
  input  logic                cfg_msb_aligned,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic                left_valid,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                right_valid
);
  localparam int LINK_W = 3;

  logic [LINK_W-1:0]   link_s;
  logic                tick, word_edge, active, commit;
  chan_e               commit_ch;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] samples [NUM_CHANNELS];
  logic                valids  [NUM_CHANNELS];

  lj_sync #(.WIDTH(LINK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sck_i, ws_i, sd_i}),
    .q_o (link_s)
  );

  lj_frame_ctl u_frame (
    .clk         (clk),
    .rst         (rst),
    .sck_s       (link_s[2]),
    .ws_s        (link_s[1]),
    .invert_i    (cfg_ws_invert),
    .tick_o      (tick),
    .edge_o      (word_edge),
    .active_o    (active),
    .commit_o    (commit),
    .commit_ch_o (commit_ch)
  );

  lj_word_asm #(.W(SAMPLE_W)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .edge_i    (word_edge),
    .active_i  (active),
    .aligned_i (cfg_msb_aligned),
    .sd_i      (link_s[0]),
    .word_o    (word)
  );

  lj_out_stage #(.W(SAMPLE_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .ch_i     (commit_ch),
    .word_i   (word),
    .sample_o (samples),
    .valid_o  (valids)
  );

  assign left_sample  = samples[CH_LEFT];
  assign left_valid   = valids[CH_LEFT];
  assign right_sample = samples[CH_RIGHT];
  assign right_valid  = valids[CH_RIGHT];
endmodule

// File: rtl/lj_stereo_rx_chk.sv
module lj_stereo_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] left_sample,
  input logic                left_valid,
  input logic [SAMPLE_W-1:0] right_sample,
  input logic                right_valid
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (left_sample == '0 && right_sample == '0 && !left_valid && !right_valid)); // R1

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    !(left_valid && right_valid)); // R8

  AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (rst)
    left_valid |=> !left_valid); // R8

  AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (rst)
    right_valid |=> !right_valid); // R8

  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !left_valid |-> $stable(left_sample)); // R9

  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !right_valid |-> $stable(right_sample)); // R9
endmodule

bind lj_stereo_rx lj_stereo_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .left_sample  (left_sample),
  .left_valid   (left_valid),
  .right_sample (right_sample),
  .right_valid  (right_valid)
);

// File: tb/sim_lj_stereo_rx.sv
module sim_lj_stereo_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic        cfg_ws_invert = 1'b0, cfg_msb_aligned = 1'b0;
  logic [15:0] left_sample, right_sample;
  logic        left_valid, right_valid;

  always #5 clk = ~clk;

  lj_stereo_rx u0 (
    .clk(clk), .rst(rst), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .cfg_ws_invert(cfg_ws_invert), .cfg_msb_aligned(cfg_msb_aligned),
    .left_sample(left_sample), .left_valid(left_valid),
    .right_sample(right_sample), .right_valid(right_valid)
  );

  int          total = 0, bad = 0;
  string       tag = "R1";
  bit          exp_ch_q[$];
  logic [15:0] exp_val_q[$];
  logic [15:0] hold_l = '0, hold_r = '0;
  logic [31:0] lfsr = 32'hACE1_2468;

  // behavioural model state
  bit          m_seen, m_started, m_prev, m_ch;
  int          m_n;
  logic [15:0] m_val;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic model_slot(input bit w, input bit d);
    if (!m_seen) begin
      m_seen = 1'b1;
      m_prev = w;
      return;
    end
    if (w != m_prev) begin
      if (m_started) begin
        if (!cfg_msb_aligned && m_n < 16) m_val[15 - m_n] = d;
        exp_ch_q.push_back(m_ch);
        exp_val_q.push_back(m_val);
      end
      m_started = 1'b1;
      m_ch  = w ^ cfg_ws_invert;
      m_val = '0;
      m_n   = 0;
      if (cfg_msb_aligned) begin
        m_val[15] = d;
        m_n = 1;
      end
    end else if (m_started && m_n < 16) begin
      m_val[15 - m_n] = d;
      m_n++;
    end
    m_prev = w;
  endtask

  task automatic drive_slot(input bit w, input bit d);
    @(negedge clk);
    ws_i = w;
    sd_i = d;
    model_slot(w, d);
    repeat (3) @(negedge clk);
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
    sck_i = 1'b0;
  endtask

  task automatic period(input bit w, input logic [31:0] bits, input int p);
    for (int k = 0; k < p; k++) drive_slot(w, bits[p - 1 - k]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(left_sample == 0 && right_sample == 0 && !left_valid && !right_valid, "R1",
          {left_sample, right_sample}, 32'h0);
    exp_ch_q.delete();
    exp_val_q.delete();
    hold_l = '0; hold_r = '0;
    m_seen = 0; m_started = 0; m_prev = 0; m_ch = 0; m_n = 0; m_val = '0;
    rst = 1'b0;
  endtask

  task automatic scenario(input string t, input bit inv, input bit aligned, input int p, input bit first_ws);
    do_reset();
    tag = t;
    cfg_ws_invert   = inv;
    cfg_msb_aligned = aligned;
    period(!first_ws, next_rand(), 5);              // stale bits before first change, R10
    for (int i = 0; i < 6; i++) period(first_ws ^ i[0], next_rand(), p);
    period(first_ws, next_rand(), 3);               // closing transition
    repeat (30) @(negedge clk);
    check(exp_ch_q.size() == 0, {"R8 pending strobes ", t}, exp_ch_q.size(), 0);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (left_valid && right_valid) check(1'b0, "R8 both valids", 2, 1);
      if (left_valid || right_valid) begin
        if (exp_ch_q.size() == 0) begin
          check(1'b0, "R8 unexpected strobe", {left_valid, right_valid}, 0);
        end else begin
          bit          ech;
          logic [15:0] ev;
          ech = exp_ch_q.pop_front();
          ev  = exp_val_q.pop_front();
          check(ech == right_valid, {"R2 channel ", tag}, right_valid, ech);
          check((right_valid ? right_sample : left_sample) == ev, {"R3 value ", tag},
                right_valid ? right_sample : left_sample, ev);
        end
        if (left_valid) hold_l = left_sample;
        if (right_valid) hold_r = right_sample;
      end
      if (!left_valid) check(left_sample == hold_l, "R9 left hold", left_sample, hold_l);
      if (!right_valid) check(right_sample == hold_r, "R9 right hold", right_sample, hold_r);
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    scenario("R3,R10 default map", 1'b0, 1'b0, 17, 1'b0);
    scenario("R2,R7 inverted aligned", 1'b1, 1'b1, 16, 1'b0);
    scenario("R4 long delayed", 1'b0, 1'b0, 24, 1'b1);
    scenario("R5 short aligned", 1'b0, 1'b1, 10, 1'b0);
    scenario("R5,R6 short delayed", 1'b1, 1'b0, 11, 1'b1);
    scenario("R4,R7 long aligned", 1'b1, 1'b1, 20, 1'b1);
    do_reset();
    summary();
  end
endmodule